// File: doc/BRIEF.md
# Masked Packed Vector Move Unit

This block performs an aligned move of packed 64-bit elements. In the load and register-copy forms it writes a source vector into a 512-bit destination register that it holds internally. In the store form it presents the source vector to a memory write port, together with per-byte write enables. The vector length is 128, 256 or 512 bits, so a move covers 2, 4 or 8 lanes.

In the extended encoding each lane can be gated by a write-mask bit. A masked-off lane is either merged, so it keeps its old contents, or zeroed. In the legacy encoding no mask applies. The encoding also decides what happens to destination bits above the vector length. The extended encoding clears them. The legacy encoding, which is legal only at 128 bits, leaves them as they were. Two faults suppress the move. The first is a memory address that is not aligned to the operand size. The second is an invalid encoding, which covers a reserved specifier field that is not all ones and an illegal length.

An operation is started by a one-cycle `in_valid` strobe. Its result, the done pulse and the fault flags appear on the next clock edge.

Top module: `masked_vec_move`

## Requirements
- R1: `vlen_sel` 0, 1 and 2 select 2, 4 and 8 lanes (128, 256 and 512 bits). Lane j occupies bits 64j+63:64j. With no mask in use, every lane below the length is copied from `src_vec`.
- R2: In the extended encoding (`ext_enc`=1) with `mask_off`=0, lane j is written only when `lane_mask[j]` is 1. With `zero_sel`=0, a masked-off lane keeps its old destination value.
- R3: In the load and register-copy forms with `zero_sel`=1, a masked-off lane below the length is cleared to zero.
- R4: When `mask_off`=1, or in the legacy encoding (`ext_enc`=0), `lane_mask` and `zero_sel` have no effect, and every lane below the length is copied.
- R5: In the load and register-copy forms, the extended encoding clears destination lanes at and above the length. The legacy encoding leaves destination bits 511:128 unchanged.
- R6: In the store form (`store_sel`=1), the destination register is unchanged and `st_data` carries `src_vec`. `st_be[8j+7:8j]` is all ones exactly when lane j is below the length and written by the R2/R4 rule. `zero_sel` is ignored, and enables for lanes above the length are low.
- R7: When `mem_sel`=1 or `store_sel`=1, the low log2(16<<`vlen_sel`) bits of `addr` must be zero. If they are not, `flt_align` is raised, the destination is unchanged and `st_be` is zero. A register copy (`store_sel`=0, `mem_sel`=0) skips this check.
- R8: `flt_ud` is raised, the destination is unchanged and `st_be` is zero when `resv_spec` is not 4'b1111, when `vlen_sel` is 3, or when the legacy encoding is used with `vlen_sel` not 0.
- R9: When both faults apply, only `flt_ud` is raised.
- R10: `done`, the fault flags, `st_be` and the destination update one clock after `in_valid`. `done` lasts one cycle. Flags and `st_be` are zero whenever `done` is low.
- R11: After reset the destination, `st_data`, `st_be`, `done` and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Starts one move |
| src_vec | input | 512 | Source vector |
| vlen_sel | input | 2 | Length code: 0=128, 1=256, 2=512, 3 illegal |
| lane_mask | input | 8 | Per-lane write mask |
| mask_off | input | 1 | No mask in use |
| zero_sel | input | 1 | 1 = zero masked-off lanes, 0 = merge |
| store_sel | input | 1 | 1 = store form, 0 = load/register-copy form |
| ext_enc | input | 1 | 1 = extended encoding, 0 = legacy |
| mem_sel | input | 1 | Operand is in memory |
| addr | input | 32 | Memory byte address |
| resv_spec | input | 4 | Reserved specifier field |
| dst_vec | output | 512 | Destination register contents |
| st_data | output | 512 | Store data for the write port |
| st_be | output | 64 | Per-byte store enables |
| done | output | 1 | One-cycle completion pulse |
| flt_align | output | 1 | Misalignment fault |
| flt_ud | output | 1 | Invalid-encoding fault |

## Verification
A full 512-bit copy first sets a known destination. Sparse masks in merge and zero mode then show old lanes kept apart from lanes cleared. No-mask and legacy moves with contradictory mask and zero inputs show that masking is really bypassed. Moves at 128 and 256 bits in both encodings tell clearing of the upper lanes apart from keeping them. Store moves compare the per-byte enables against the destination staying unchanged. Misaligned addresses at each size, bad reserved fields and illegal lengths, alone and combined, check suppression and fault priority. Random mixes of all of these, with mostly aligned addresses, follow.

// File: rtl/vm_pkg.sv
package vm_pkg;
    typedef enum logic [1:0] {
        VL128  = 2'd0,
        VL256  = 2'd1,
        VL512  = 2'd2,
        VLRSVD = 2'd3
    } vlen_e;
endpackage

// File: rtl/vm_lane_ctl.sv
module vm_lane_ctl #(
    parameter int LANES = 8
) (
    input  logic [1:0]       vlen,
    input  logic [LANES-1:0] mask,
    input  logic             mask_off,
    input  logic             ext,
    output logic [LANES-1:0] in_vl,
    output logic [LANES-1:0] wr_en
);
    localparam int CW = $clog2(LANES) + 3;

    logic [CW-1:0] n_lanes;
    logic          use_mask;

    assign n_lanes  = CW'(2) << vlen;
    assign use_mask = ext && !mask_off;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign in_vl[j] = CW'(j) < n_lanes;
        assign wr_en[j] = in_vl[j] && (!use_mask || mask[j]);
    end
endmodule

// File: rtl/vm_fault_chk.sv
module vm_fault_chk #(
    parameter int ADDR_W     = 32,
    parameter int LANE_BYTES = 8,
    parameter int RESV_W     = 4
) (
    input  logic [1:0]        vlen,
    input  logic              ext,
    input  logic              store,
    input  logic              mem_op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [RESV_W-1:0] resv,
    output logic              ud,
    output logic              misalign
);
    import vm_pkg::*;

    logic [ADDR_W-1:0] low_mask;

    assign low_mask = (ADDR_W'(2 * LANE_BYTES) << vlen) - ADDR_W'(1);

    always_comb begin
        ud       = (resv != {RESV_W{1'b1}})
                || (vlen == VLRSVD)
                || (!ext && vlen != VL128);
        misalign = !ud && (mem_op || store) && ((addr & low_mask) != '0);
    end
endmodule

// File: rtl/vm_lane_merge.sv
module vm_lane_merge #(
    parameter int LANE_W = 64,
    parameter int LANES  = 8
) (
    input  logic [LANE_W*LANES-1:0] src,
    input  logic [LANE_W*LANES-1:0] old,
    input  logic [LANES-1:0]        in_vl,
    input  logic [LANES-1:0]        wr_en,
    input  logic                    zero_mode,
    input  logic                    ext,
    output logic [LANE_W*LANES-1:0] merged
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [LANE_W-1:0] s_l, o_l, r_l;
        assign s_l = src[j*LANE_W +: LANE_W];
        assign o_l = old[j*LANE_W +: LANE_W];
        always_comb begin
            if (in_vl[j]) begin
                if (wr_en[j])       r_l = s_l;
                else if (zero_mode) r_l = '0;
                else                r_l = o_l;
            end else begin
                r_l = ext ? '0 : o_l;
            end
        end
        assign merged[j*LANE_W +: LANE_W] = r_l;
    end
endmodule

// File: rtl/masked_vec_move.sv
module masked_vec_move #(
    parameter int LANE_W = 64,
    parameter int LANES  = 8,
    parameter int ADDR_W = 32,
    parameter int RESV_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [LANE_W*LANES-1:0]     src_vec,
    input  logic [1:0]                  vlen_sel,
    input  logic [LANES-1:0]            lane_mask,
    input  logic                        mask_off,
    input  logic                        zero_sel,
    input  logic                        store_sel,
    input  logic                        ext_enc,
    input  logic                        mem_sel,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [RESV_W-1:0]           resv_spec,
    output logic [LANE_W*LANES-1:0]     dst_vec,
    output logic [LANE_W*LANES-1:0]     st_data,
    output logic [LANE_W*LANES/8-1:0]   st_be,
    output logic                        done,
    output logic                        flt_align,
    output logic                        flt_ud
);
    localparam int VEC_W      = LANE_W * LANES;
    localparam int LANE_BYTES = LANE_W / 8;
    localparam int BYTES      = VEC_W / 8;

    typedef struct packed {
        logic [VEC_W-1:0] dst;
        logic [VEC_W-1:0] sdata;
        logic [BYTES-1:0] be;
        logic             done;
        logic             f_align;
        logic             f_ud;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0] in_vl, wr_en;
    logic [VEC_W-1:0] merged;
    logic [BYTES-1:0] be_full;
    logic             ud, misalign;

    vm_lane_ctl #(.LANES(LANES)) u_lane_ctl (
        .vlen     (vlen_sel),
        .mask     (lane_mask),
        .mask_off (mask_off),
        .ext      (ext_enc),
        .in_vl    (in_vl),
        .wr_en    (wr_en)
    );

    vm_fault_chk #(
        .ADDR_W     (ADDR_W),
        .LANE_BYTES (LANE_BYTES),
        .RESV_W     (RESV_W)
    ) u_fault_chk (
        .vlen     (vlen_sel),
        .ext      (ext_enc),
        .store    (store_sel),
        .mem_op   (mem_sel),
        .addr     (addr),
        .resv     (resv_spec),
        .ud       (ud),
        .misalign (misalign)
    );

    vm_lane_merge #(.LANE_W(LANE_W), .LANES(LANES)) u_merge (
        .src       (src_vec),
        .old       (st_q.dst),
        .in_vl     (in_vl),
        .wr_en     (wr_en),
        .zero_mode (zero_sel),
        .ext       (ext_enc),
        .merged    (merged)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_be
        assign be_full[j*LANE_BYTES +: LANE_BYTES] = {LANE_BYTES{wr_en[j]}};
    end

    always_comb begin
        st_d         = st_q;
        st_d.done    = in_valid;
        st_d.f_ud    = 1'b0;
        st_d.f_align = 1'b0;
        st_d.be      = '0;
        if (in_valid) begin
            st_d.f_ud    = ud;
            st_d.f_align = misalign;
            if (!ud && !misalign) begin
                if (store_sel) begin
                    st_d.be    = be_full;
                    st_d.sdata = src_vec;
                end else begin
                    st_d.dst = merged;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dst_vec   = st_q.dst;
    assign st_data   = st_q.sdata;
    assign st_be     = st_q.be;
    assign done      = st_q.done;
    assign flt_align = st_q.f_align;
    assign flt_ud    = st_q.f_ud;
endmodule

// File: rtl/vm_move_chk.sv
module vm_move_chk #(
    parameter int VEC_W = 512,
    parameter int BYTES = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             store_sel,
    input logic [VEC_W-1:0] dst_vec,
    input logic [BYTES-1:0] st_be,
    input logic             done,
    input logic             flt_align,
    input logic             flt_ud
);
    a_r9_fault_priority: assert property (@(posedge clk) disable iff (!rst_n)
        !(flt_ud && flt_align));

    a_r10_done_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (st_be == '0 && !flt_align && !flt_ud));

    a_r8_fault_no_be: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_ud || flt_align) |-> st_be == '0);

    a_r7_fault_keeps_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (flt_ud || flt_align)) |-> $stable(dst_vec));

    a_r6_store_keeps_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && store_sel) |=> $stable(dst_vec));

    a_r10_no_change_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(dst_vec));
endmodule

bind masked_vec_move vm_move_chk #(.VEC_W(LANE_W*LANES), .BYTES(LANE_W*LANES/8)) u_vm_move_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .store_sel (store_sel),
    .dst_vec   (dst_vec),
    .st_be     (st_be),
    .done      (done),
    .flt_align (flt_align),
    .flt_ud    (flt_ud)
);

// File: tb/tb_masked_vec_move.sv
`timescale 1ns/100ps
module tb_masked_vec_move;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] src_vec = '0;
    logic [1:0]   vlen_sel = '0;
    logic [7:0]   lane_mask = '0;
    logic         mask_off = 1'b0, zero_sel = 1'b0, store_sel = 1'b0;
    logic         ext_enc = 1'b0, mem_sel = 1'b0;
    logic [31:0]  addr = '0;
    logic [3:0]   resv_spec = 4'hF;
    logic [511:0] dst_vec, st_data;
    logic [63:0]  st_be;
    logic         done, flt_align, flt_ud;

    int checks = 0;
    int failures = 0;
    logic [511:0] mdl_dst = '0;

    always #2.5 clk = ~clk;

    masked_vec_move dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .vlen_sel(vlen_sel), .lane_mask(lane_mask), .mask_off(mask_off),
        .zero_sel(zero_sel), .store_sel(store_sel), .ext_enc(ext_enc),
        .mem_sel(mem_sel), .addr(addr), .resv_spec(resv_spec),
        .dst_vec(dst_vec), .st_data(st_data), .st_be(st_be), .done(done),
        .flt_align(flt_align), .flt_ud(flt_ud)
    );

    task automatic chk(string tag, string what, logic [511:0] act, logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [511:0] rnd_vec();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom();
        return v;
    endfunction

    task automatic do_op(string tag, logic [1:0] vl, logic [7:0] m, bit nm, bit z,
                         bit st, bit ex, bit mo, logic [31:0] a, logic [3:0] rs,
                         logic [511:0] s);
        bit           e_ud, e_al, inv, wr;
        int           nl, sz;
        logic [511:0] e_dst;
        logic [63:0]  e_be;
        e_ud  = (rs != 4'hF) || (vl == 2'd3) || (!ex && vl != 2'd0);
        sz    = 16 << vl;
        e_al  = !e_ud && (mo || st) && ((a % sz) != 0);
        nl    = 2 << vl;
        e_dst = mdl_dst;
        e_be  = '0;
        if (!e_ud && !e_al) begin
            for (int j = 0; j < 8; j++) begin
                inv = j < nl;
                wr  = inv && (!ex || nm || m[j]);
                if (st) begin
                    e_be[j*8 +: 8] = {8{wr}};
                end else if (inv) begin
                    e_dst[j*64 +: 64] = wr ? s[j*64 +: 64] : (z ? 64'd0 : mdl_dst[j*64 +: 64]);
                end else if (ex) begin
                    e_dst[j*64 +: 64] = 64'd0;
                end
            end
        end
        @(negedge clk);
        vlen_sel = vl; lane_mask = m; mask_off = nm; zero_sel = z; store_sel = st;
        ext_enc = ex; mem_sel = mo; addr = a; resv_spec = rs; src_vec = s;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(tag, "dst", dst_vec, e_dst);
        chk(tag, "be", {448'd0, st_be}, {448'd0, e_be});
        chk(tag, "flags", {510'd0, flt_ud, flt_align}, {510'd0, e_ud, e_al});
        chk(tag, "done", {511'd0, done}, 512'd1);
        if (st && !e_ud && !e_al) chk(tag, "st_data", st_data, s);
        mdl_dst = e_dst;
        @(negedge clk);
        chk("R10", "done_low", {509'd0, done, flt_ud, flt_align}, 512'd0);
        chk("R10", "be_low", {448'd0, st_be}, 512'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [511:0] p;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R11", "reset", {dst_vec[510:0], done}, 512'd0);
        chk("R11", "reset_out", {st_data[446:0], st_be, flt_ud, flt_align, done}, 512'd0);
        rst_n = 1'b1;
        @(negedge clk);

        p = rnd_vec();
        do_op("R1", 2'd2, 8'h00, 1, 0, 0, 1, 0, 32'h0, 4'hF, p);
        do_op("R2", 2'd2, 8'hA5, 0, 0, 0, 1, 1, 32'h40, 4'hF, rnd_vec());
        do_op("R3", 2'd2, 8'h3C, 0, 1, 0, 1, 0, 32'h0, 4'hF, rnd_vec());
        do_op("R1", 2'd2, 8'h00, 1, 0, 0, 1, 0, 32'h0, 4'hF, rnd_vec());
        do_op("R4", 2'd2, 8'h00, 1, 1, 0, 1, 0, 32'h0, 4'hF, rnd_vec());
        do_op("R5", 2'd1, 8'hFF, 0, 0, 0, 1, 1, 32'h20, 4'hF, rnd_vec());
        do_op("R1", 2'd2, 8'h00, 1, 0, 0, 1, 0, 32'h0, 4'hF, rnd_vec());
        do_op("R5", 2'd0, 8'h00, 0, 1, 0, 0, 1, 32'h10, 4'hF, rnd_vec());
        do_op("R4", 2'd0, 8'h00, 0, 1, 0, 0, 0, 32'h0, 4'hF, rnd_vec());
        do_op("R5", 2'd0, 8'h01, 0, 1, 0, 1, 0, 32'h0, 4'hF, rnd_vec());
        do_op("R6", 2'd2, 8'h5A, 0, 1, 1, 1, 1, 32'h80, 4'hF, rnd_vec());
        do_op("R6", 2'd1, 8'hFF, 0, 0, 1, 1, 0, 32'h20, 4'hF, rnd_vec());
        do_op("R6", 2'd0, 8'h00, 0, 0, 1, 0, 1, 32'h30, 4'hF, rnd_vec());
        do_op("R7", 2'd2, 8'hFF, 0, 0, 0, 1, 1, 32'h20, 4'hF, rnd_vec());
        do_op("R7", 2'd1, 8'hFF, 0, 0, 1, 1, 1, 32'h10, 4'hF, rnd_vec());
        do_op("R7", 2'd0, 8'hFF, 0, 0, 0, 1, 1, 32'h8, 4'hF, rnd_vec());
        do_op("R7", 2'd2, 8'hFF, 0, 0, 0, 1, 0, 32'h8, 4'hF, rnd_vec());
        do_op("R8", 2'd2, 8'hFF, 1, 0, 0, 1, 0, 32'h0, 4'hE, rnd_vec());
        do_op("R8", 2'd3, 8'hFF, 1, 0, 0, 1, 0, 32'h0, 4'hF, rnd_vec());
        do_op("R8", 2'd1, 8'hFF, 1, 0, 0, 0, 0, 32'h0, 4'hF, rnd_vec());
        do_op("R9", 2'd2, 8'hFF, 1, 0, 1, 1, 1, 32'h4, 4'h7, rnd_vec());

        for (int i = 0; i < 300; i++) begin
            logic [31:0] a;
            a = $urandom();
            if (($urandom() % 10) < 7) a = a & ~32'h3F;
            do_op("R1", 2'($urandom() % 4), 8'($urandom()), 1'($urandom() % 4 == 0),
                  1'($urandom()), 1'($urandom() % 3 == 0), 1'($urandom() % 5 != 0),
                  1'($urandom()), a, ($urandom() % 8 == 0) ? 4'($urandom()) : 4'hF,
                  rnd_vec());
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule